// File: doc/BRIEF.md
# Low-Power SDRAM Power-Mode Sequencer

This block issues the command stream that brings a low-power SDRAM up from power-on and puts it into and out of its deepest power-saving state. A configuration write carries three mode bits: a refresh-enable bit, a deep-mode select bit and a refresh-mode bit. The block turns them into the clock-enable level and a four-bit command code on the chip-select, row-strobe, column-strobe and write-enable lines. Separate bank-select and auto-precharge address outputs accompany the command code.

After reset, and again after every exit from deep power-down, the block runs the whole bring-up sequence. That sequence is a precharge of all banks, two auto-refreshes, a mode register load and then an extended mode register load. Each command is followed by a programmable number of NOP cycles. The ready output gates normal accesses elsewhere in the controller. It is high only while the device is initialized and awake. While the device sits in deep power-down no refresh is issued, so its contents are treated as lost.

Top module: `lpsdr_pwr_seq`

## Requirements
- R1: While reset is high, the outputs are clock-enable high, command NOP (code 0111), bank 00, auto-precharge bit low and ready low. The precharge-all command appears in the first cycle after reset is released.
- R2: Bring-up issues commands in this fixed order: precharge-all (code 0010 with the auto-precharge bit high), auto-refresh (0001), a second auto-refresh (0001), mode register load (0000 with bank 00), and extended mode register load (0000 with bank 10). Clock-enable stays high throughout.
- R3: Each command is followed by exactly N NOP cycles. N is t_prech after precharge-all, t_refi after each auto-refresh, t_mrd after the mode load and t_emrd after the extended load. A programmed value of 0 counts as 1.
- R4: Ready rises in the cycle after the last NOP that follows the extended mode load. While ready is high, the command is NOP and clock-enable is high.
- R5: Deep power-down entry needs a mode write that moves the stored refresh-mode bit from 0 to 1, while ready is high and the stored deep-mode and refresh-enable bits are already 1. In the cycle after that write, the outputs are clock-enable low, command 0110 and ready low.
- R6: A mode write does not start entry when the stored deep-mode bit or the stored refresh-enable bit was 0 before the write. This holds even if the same write sets that bit. Nor does a write start entry when the stored refresh-mode bit is already 1.
- R7: In deep power-down, clock-enable stays low, the command stays NOP after the entry cycle, no refresh is issued and ready stays low. Mode writes that keep the refresh-mode bit at 1 change none of this.
- R8: A mode write with the refresh-mode bit at 0 during deep power-down raises clock-enable with a NOP in the next cycle. The complete R2/R3 sequence then follows, and ready stays low until it ends.
- R9: While a bring-up sequence is running, mode writes leave the stored refresh-mode bit unchanged. The refresh-enable and deep-mode bits are still updated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Strobe that writes the three mode bits |
| mode_refen | input | 1 | Refresh-enable bit |
| mode_deep | input | 1 | Deep-mode select bit |
| mode_rmode | input | 1 | Refresh-mode bit |
| t_prech | input | CNT_W | NOP cycles after precharge-all |
| t_refi | input | CNT_W | NOP cycles after each auto-refresh |
| t_mrd | input | CNT_W | NOP cycles after the mode register load |
| t_emrd | input | CNT_W | NOP cycles after the extended mode register load |
| cke | output | 1 | Clock-enable to the SDRAM |
| cmd_n | output | 4 | Command code {cs, ras, cas, we}, active low |
| bank | output | 2 | Bank-select bits (10 marks the extended mode load) |
| a10 | output | 1 | Auto-precharge/all-banks address bit |
| ready | output | 1 | Device initialized and awake |

## Verification
The hardest case to reach from the ports is a refresh-mode write that lands during bring-up. From outside it leaves no trace until a later entry attempt succeeds or fails. The stimulus pokes an all-ones mode write part-way through each sequence. It then expects the next all-ones write after ready to enter deep power-down, which only works if the earlier refresh-mode bit was dropped. The entry conditions that fail because the deep-mode or refresh-enable bit was only set in the same write are reached by directed write sequences. Random wait counts, including zero, and random dwell times in deep power-down vary the sequence lengths. Those include an exit written in the very cycle of the entry command.

// File: rtl/lpsdr_pkg.sv
package lpsdr_pkg;

  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_PALL = 4'b0010;
  localparam logic [3:0] CMD_REF  = 4'b0001;
  localparam logic [3:0] CMD_MODE = 4'b0000;
  localparam logic [3:0] CMD_DPD  = 4'b0110;

  localparam logic [1:0] BANK_STD = 2'b00;
  localparam logic [1:0] BANK_EXT = 2'b10;

  localparam int N_WAITS = 4;

  typedef enum logic [3:0] {
    ST_WAKE,
    ST_PALL,
    ST_WAIT_P,
    ST_REF1,
    ST_WAIT_R1,
    ST_REF2,
    ST_WAIT_R2,
    ST_MRS,
    ST_WAIT_M,
    ST_EMRS,
    ST_WAIT_E,
    ST_READY,
    ST_DPD_ENTER,
    ST_DPD
  } seq_state_t;

  typedef struct packed {
    logic       cke;
    logic [3:0] cmd;
    logic [1:0] ba;
    logic       a10;
    logic       ready;
  } pin_bundle_t;

  function automatic logic is_init(seq_state_t s);
    return s inside {ST_WAKE, ST_PALL, ST_WAIT_P, ST_REF1, ST_WAIT_R1,
                     ST_REF2, ST_WAIT_R2, ST_MRS, ST_WAIT_M, ST_EMRS,
                     ST_WAIT_E};
  endfunction

endpackage

// File: rtl/lpsdr_wait_ctr.sv
module lpsdr_wait_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/lpsdr_mode_bits.sv
module lpsdr_mode_bits (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic refen_i,
  input  logic deep_i,
  input  logic rmode_i,
  input  logic lock_rmode,
  output logic enter_req,
  output logic exit_req
);

  logic refen_q, deep_q, rmode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      refen_q <= 1'b0;
      deep_q  <= 1'b0;
      rmode_q <= 1'b0;
    end else if (wr) begin
      refen_q <= refen_i;
      deep_q  <= deep_i;
      if (!lock_rmode) begin
        rmode_q <= rmode_i;
      end
    end
  end

  assign enter_req = wr && rmode_i && !rmode_q && deep_q && refen_q && !lock_rmode;
  assign exit_req  = wr && !rmode_i;

endmodule

// File: rtl/lpsdr_cmd_enc.sv
module lpsdr_cmd_enc
  import lpsdr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  seq_state_t  nxt,
  output pin_bundle_t pins
);

  pin_bundle_t d;

  always_comb begin
    d       = '0;
    d.cke   = 1'b1;
    d.cmd   = CMD_NOP;
    d.ba    = BANK_STD;
    case (nxt)
      ST_PALL: begin
        d.cmd = CMD_PALL;
        d.a10 = 1'b1;
      end
      ST_REF1, ST_REF2: d.cmd = CMD_REF;
      ST_MRS:  d.cmd = CMD_MODE;
      ST_EMRS: begin
        d.cmd = CMD_MODE;
        d.ba  = BANK_EXT;
      end
      ST_READY: d.ready = 1'b1;
      ST_DPD_ENTER: begin
        d.cke = 1'b0;
        d.cmd = CMD_DPD;
      end
      ST_DPD: d.cke = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pins <= '{cke: 1'b1, cmd: CMD_NOP, ba: BANK_STD, a10: 1'b0, ready: 1'b0};
    end else begin
      pins <= d;
    end
  end

endmodule

// File: rtl/lpsdr_pwr_seq.sv
module lpsdr_pwr_seq
  import lpsdr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  logic             mode_refen,
  input  logic             mode_deep,
  input  logic             mode_rmode,
  input  logic [CNT_W-1:0] t_prech,
  input  logic [CNT_W-1:0] t_refi,
  input  logic [CNT_W-1:0] t_mrd,
  input  logic [CNT_W-1:0] t_emrd,
  output logic             cke,
  output logic [3:0]       cmd_n,
  output logic [1:0]       bank,
  output logic             a10,
  output logic             ready
);

  seq_state_t       st, nxt;
  logic             enter_req, exit_req, expired;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic [CNT_W-1:0] t_sel  [N_WAITS];
  logic [CNT_W-1:0] t_load [N_WAITS];
  pin_bundle_t      pins;

  assign t_sel[0] = t_prech;
  assign t_sel[1] = t_refi;
  assign t_sel[2] = t_mrd;
  assign t_sel[3] = t_emrd;

  // A programmed wait of 0 is treated as 1; the counter holds N-1.
  for (genvar g = 0; g < N_WAITS; g++) begin : g_wait
    assign t_load[g] = (t_sel[g] == '0) ? '0 : t_sel[g] - CNT_W'(1);
  end

  lpsdr_mode_bits u_mode (
    .clk        (clk),
    .rst        (rst),
    .wr         (mode_wr),
    .refen_i    (mode_refen),
    .deep_i     (mode_deep),
    .rmode_i    (mode_rmode),
    .lock_rmode (is_init(st)),
    .enter_req  (enter_req),
    .exit_req   (exit_req)
  );

  lpsdr_wait_ctr #(.CNT_W(CNT_W)) u_wait (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .expired  (expired)
  );

  always_comb begin
    ld     = 1'b1;
    ld_val = '0;
    case (st)
      ST_PALL:          ld_val = t_load[0];
      ST_REF1, ST_REF2: ld_val = t_load[1];
      ST_MRS:           ld_val = t_load[2];
      ST_EMRS:          ld_val = t_load[3];
      default:          ld     = 1'b0;
    endcase
  end

  always_comb begin
    nxt = st;
    case (st)
      ST_WAKE:      nxt = ST_PALL;
      ST_PALL:      nxt = ST_WAIT_P;
      ST_WAIT_P:    if (expired) nxt = ST_REF1;
      ST_REF1:      nxt = ST_WAIT_R1;
      ST_WAIT_R1:   if (expired) nxt = ST_REF2;
      ST_REF2:      nxt = ST_WAIT_R2;
      ST_WAIT_R2:   if (expired) nxt = ST_MRS;
      ST_MRS:       nxt = ST_WAIT_M;
      ST_WAIT_M:    if (expired) nxt = ST_EMRS;
      ST_EMRS:      nxt = ST_WAIT_E;
      ST_WAIT_E:    if (expired) nxt = ST_READY;
      ST_READY:     if (enter_req) nxt = ST_DPD_ENTER;
      ST_DPD_ENTER: nxt = exit_req ? ST_WAKE : ST_DPD;
      ST_DPD:       if (exit_req) nxt = ST_WAKE;
      default:      nxt = ST_WAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_WAKE;
    else     st <= nxt;
  end

  lpsdr_cmd_enc u_enc (
    .clk  (clk),
    .rst  (rst),
    .nxt  (nxt),
    .pins (pins)
  );

  assign cke   = pins.cke;
  assign cmd_n = pins.cmd;
  assign bank  = pins.ba;
  assign a10   = pins.a10;
  assign ready = pins.ready;

endmodule

// File: rtl/lpsdr_pwr_seq_chk.sv
module lpsdr_pwr_seq_chk
  import lpsdr_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic [3:0] cmd_n,
  input logic [1:0] bank,
  input logic       a10,
  input logic       ready
);

  // R2
  pall_a10_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_n == CMD_PALL) |-> (a10 && bank == BANK_STD && cke));

  // R2
  mode_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_n == CMD_MODE) |-> (bank == BANK_STD || bank == BANK_EXT));

  // R3
  cmd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_n != CMD_NOP) |=> (cmd_n == CMD_NOP));

  // R4
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> (cmd_n == CMD_NOP && cke));

  // R4
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(cmd_n) == CMD_NOP && $past(cke)));

  // R5
  dpd_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> (cmd_n == CMD_DPD && !ready && $past(ready)));

  // R7
  dpd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cke |-> ((cmd_n == CMD_NOP || cmd_n == CMD_DPD) && !ready));

  // R8
  wake_nop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> (cmd_n == CMD_NOP && !ready));

  // R8
  wake_pall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |=> (cmd_n == CMD_PALL));

endmodule

bind lpsdr_pwr_seq lpsdr_pwr_seq_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .cke   (cke),
  .cmd_n (cmd_n),
  .bank  (bank),
  .a10   (a10),
  .ready (ready)
);

// File: tb/sim_lpsdr_pwr_seq.sv
module sim_lpsdr_pwr_seq;

  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_wr = 1'b0, m_refen = 1'b0, m_deep = 1'b0, m_rmode = 1'b0;
  logic [CW-1:0] t_p = 8'd2, t_r = 8'd3, t_m = 8'd1, t_e = 8'd2;
  logic cke, a10, ready;
  logic [3:0] cmd_n;
  logic [1:0] bank;

  int vecs = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lpsdr_pwr_seq #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_refen(m_refen),
    .mode_deep(m_deep), .mode_rmode(m_rmode), .t_prech(t_p), .t_refi(t_r),
    .t_mrd(t_m), .t_emrd(t_e), .cke(cke), .cmd_n(cmd_n), .bank(bank),
    .a10(a10), .ready(ready)
  );

  // {cke, cmd, bank, a10, ready}
  localparam logic [8:0] V_WAKE  = {1'b1, 4'b0111, 2'b00, 1'b0, 1'b0};
  localparam logic [8:0] V_NOP   = {1'b1, 4'b0111, 2'b00, 1'b0, 1'b0};
  localparam logic [8:0] V_PALL  = {1'b1, 4'b0010, 2'b00, 1'b1, 1'b0};
  localparam logic [8:0] V_REF   = {1'b1, 4'b0001, 2'b00, 1'b0, 1'b0};
  localparam logic [8:0] V_MRS   = {1'b1, 4'b0000, 2'b00, 1'b0, 1'b0};
  localparam logic [8:0] V_EMRS  = {1'b1, 4'b0000, 2'b10, 1'b0, 1'b0};
  localparam logic [8:0] V_READY = {1'b1, 4'b0111, 2'b00, 1'b0, 1'b1};
  localparam logic [8:0] V_DPDIN = {1'b0, 4'b0110, 2'b00, 1'b0, 1'b0};
  localparam logic [8:0] V_DPD   = {1'b0, 4'b0111, 2'b00, 1'b0, 1'b0};

  function automatic int eff(int n);
    return (n == 0) ? 1 : n;
  endfunction

  // Index of the first ready cycle; index 0 is the wake NOP.
  function automatic int ready_idx();
    return 6 + eff(t_p) + 2 * eff(t_r) + eff(t_m) + eff(t_e);
  endfunction

  function automatic logic [8:0] exp_at(int i);
    int p1, p2, p3, p4;
    p1 = 2 + eff(t_p);
    p2 = p1 + 1 + eff(t_r);
    p3 = p2 + 1 + eff(t_r);
    p4 = p3 + 1 + eff(t_m);
    if (i == 0)                return V_WAKE;
    if (i == 1)                return V_PALL;
    if (i == p1 || i == p2)    return V_REF;
    if (i == p3)               return V_MRS;
    if (i == p4)               return V_EMRS;
    if (i >= ready_idx())      return V_READY;
    return V_NOP;
  endfunction

  task automatic check(input logic [8:0] exp, input string tag);
    logic [8:0] got;
    got = {cke, cmd_n, bank, a10, ready};
    vecs++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp);
    end
  endtask

  // Mode write at a negedge; returns at the next negedge with outputs updated.
  task automatic write_mode(input logic r, input logic d, input logic m);
    m_refen = r; m_deep = d; m_rmode = m; mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  // Walks a bring-up sequence from index 'first' through the ready cycle.
  task automatic run_init(input int first, input bit poke);
    for (int i = first; i <= ready_idx(); i++) begin
      @(negedge clk);
      mode_wr = 1'b0;
      if (i == 0)               check(exp_at(i), "R8 wake nop");
      else if (i < ready_idx()) check(exp_at(i), "R2/R3 init order and waits");
      else                      check(exp_at(i), "R4 ready after emrs wait");
      if (poke && i == 3) begin
        m_refen = 1'b1; m_deep = 1'b1; m_rmode = 1'b1; mode_wr = 1'b1; // R9
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(V_WAKE, "R1 reset state");
    rst = 1'b0;
    run_init(1, 1'b1);

    // R9: the refresh-mode bit written during init was ignored, so this enters.
    write_mode(1'b1, 1'b1, 1'b1);
    check(V_DPDIN, "R5 R9 entry after ignored init write");
    for (int k = 0; k < 4; k++) begin
      if (k == 1) write_mode(1'b0, 1'b1, 1'b1);
      else @(negedge clk);
      check(V_DPD, "R7 dpd holds cke low, no refresh");
    end

    // R8: exit with all waits programmed to zero (treated as one, R3).
    t_p = '0; t_r = '0; t_m = '0; t_e = '0;
    m_refen = 1'b1; m_deep = 1'b0; m_rmode = 1'b0; mode_wr = 1'b1;
    run_init(0, 1'b0);

    // R6: deep bit only set in the same write does not count.
    write_mode(1'b1, 1'b1, 1'b1);
    check(V_READY, "R6 deep not already set");
    write_mode(1'b1, 1'b1, 1'b1);
    check(V_READY, "R6 refresh-mode already 1, no rising write");
    write_mode(1'b0, 1'b1, 1'b0);
    check(V_READY, "R6 clear refresh-mode while ready");
    write_mode(1'b1, 1'b1, 1'b1);
    check(V_READY, "R6 refresh-enable not already set");
    write_mode(1'b1, 1'b1, 1'b0);
    check(V_READY, "R6 refresh-mode cleared");
    write_mode(1'b1, 1'b1, 1'b1);
    check(V_DPDIN, "R5 entry with both bits already set");

    for (int it = 0; it < 24; it++) begin
      int dwell;
      bit poke;
      dwell = int'($urandom % 5);
      poke  = 1'(($urandom % 2));
      for (int k = 0; k < dwell; k++) begin
        if (($urandom % 3) == 0) write_mode(1'($urandom % 2), 1'b1, 1'b1);
        else @(negedge clk);
        check(V_DPD, "R7 dpd dwell");
      end
      t_p = CW'($urandom % 6); t_r = CW'($urandom % 6);
      t_m = CW'($urandom % 6); t_e = CW'($urandom % 6);
      m_refen = 1'b1; m_deep = 1'b1; m_rmode = 1'b0; mode_wr = 1'b1;
      run_init(0, poke);
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        check(V_READY, "R4 ready holds");
      end
      write_mode(1'b1, 1'b1, 1'b1);
      check(V_DPDIN, "R5 random entry");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule